// File: doc/BRIEF.md
# Synchronizable Up-Down PWM Time Base

This block is the time base of one PWM channel. Its counter runs a symmetric triangle: from zero it climbs to the active period, then it descends back to zero. A full carrier cycle is therefore twice the period value in clocks. Software writes new period values into a shadow register. The counter picks them up only at a cycle boundary, so a carrier cycle is never cut short or stretched partway through.

Channels are chained through a sync input and a sync output. When a sync pulse arrives and phase loading is enabled, the counter jumps to a programmed phase value and takes a programmed direction. A follower that is reloaded on every leader zero stays locked to the leader even if the leader's period is dithered. The sync output can pass the incoming pulse through, emit its own pulse on counter zero, or stay quiet. The quiet setting splits a chain into independent time domains.

Top module: `sync_pwm_timebase`

## Requirements
- R1: Reset (rst_ni low, asynchronous) forces cnt_o to 0 and dir_o to 0 (up). Both the active period and the shadow period take the parameter RST_PRD.
- R2: While dir_o is 0 and cnt_o is below the active period, cnt_o rises by one on each clock. When cnt_o is at or above the active period, the next clock sets dir_o to 1 (down) and lowers cnt_o by one.
- R3: While dir_o is 1, cnt_o falls by one on each clock. When cnt_o is 0, the next clock sets dir_o to 0 and cnt_o to 1. With no sync loads and a period P of at least 1, the carrier cycle is 2*P clocks.
- R4: A clock with prd_wr_i high stores prd_i in the shadow period. The shadow moves into the active period only on a clock edge where cnt_o is 0, and that edge uses the shadow value held before any write on the same edge. On every other edge the active period holds.
- R5: A clock with sync_i and phase_en_i both high loads cnt_o with phase_i and dir_o with phase_dir_i (0 up, 1 down). This load overrides normal counting.
- R6: With phase_en_i low, sync_i has no effect on cnt_o or dir_o.
- R7: sync_sel_i selects the sync output. The value 2'b00 drives sync_o with sync_i. The value 2'b01 drives sync_o high exactly while cnt_o is 0. The values 2'b10 and 2'b11 hold sync_o low.
- R8: zero_o is high exactly when cnt_o is 0. prd_o is high exactly when cnt_o equals the active period.
- R9: A phase value above the active period, loaded with direction up, turns the counter down on the next clock. From there it counts down to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prd_i | input | CNT_W | New period value (must be at least 1) |
| prd_wr_i | input | 1 | Write prd_i into the shadow period |
| phase_i | input | CNT_W | Value loaded on sync |
| phase_en_i | input | 1 | Enable phase load on sync |
| phase_dir_i | input | 1 | Direction after a phase load, 0 up, 1 down |
| sync_sel_i | input | 2 | Sync output source select |
| sync_i | input | 1 | Sync pulse from upstream channel |
| cnt_o | output | CNT_W | Counter value |
| dir_o | output | 1 | Count direction, 0 up, 1 down |
| zero_o | output | 1 | Counter equals zero |
| prd_o | output | 1 | Counter equals active period |
| sync_o | output | 1 | Sync pulse to downstream channel |

## Verification
A period written in the middle of a carrier cycle, and a write on the very edge where the counter sits at zero, check that the active period changes only at zero. A design that transferred immediately would truncate or stretch the current ramp. A design that transferred on the period match would shift the waveform by half a cycle.

Sync pulses are driven with phase loading off and with it on, in both directions. A design that ignored the enable would jump the counter. One that dropped the programmed direction would climb where it should fall.

A phase value above the period checks that the counter turns down at once. A design that tested only equality would wrap through the whole counter range.

Each sync output setting is swept while the counter crosses zero. This exposes a leaking disabled output or a zero pulse that is off by a clock.

// File: rtl/utb_pkg.sv
`timescale 1ns/1ps
package utb_pkg;
  typedef enum logic [1:0] {
    SYNC_PASS = 2'b00,
    SYNC_ZERO = 2'b01,
    SYNC_OFF  = 2'b10
  } sync_sel_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/utb_period_shadow.sv
`timescale 1ns/1ps
module utb_period_shadow #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_PRD = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic             xfer_i,
  output logic [CNT_W-1:0] prd_act_o
);
  localparam logic [CNT_W-1:0] PrdInit = CNT_W'(RST_PRD);

  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= PrdInit;
      active_q <= PrdInit;
    end else begin
      if (wr_i)   shadow_q <= prd_i;
      // transfer uses the shadow value held before this edge's write
      if (xfer_i) active_q <= shadow_q;
    end
  end

  assign prd_act_o = active_q;
endmodule

// File: rtl/utb_updown_core.sv
`timescale 1ns/1ps
module utb_updown_core
  import utb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] prd_act_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic             phase_dir_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             zero_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  dir_e             dir_q, dir_d;
  logic             at_zero, at_top;

  assign at_zero = (cnt_q == '0);
  // at-or-above covers phase loads beyond the period
  assign at_top  = (cnt_q >= prd_act_i);

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (load_i) begin
      cnt_d = phase_i;
      dir_d = dir_e'(phase_dir_i);
    end else if (dir_q == DIR_UP) begin
      if (at_top) begin
        dir_d = DIR_DOWN;
        cnt_d = at_zero ? '0 : cnt_q - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (at_zero) begin
        dir_d = DIR_UP;
        cnt_d = CNT_W'(1);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign dir_o   = dir_q;
  assign zero_o  = at_zero;
  assign match_o = (cnt_q == prd_act_i);
endmodule

// File: rtl/utb_sync_route.sv
`timescale 1ns/1ps
module utb_sync_route
  import utb_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       sync_i,
  input  logic       zero_i,
  output logic       sync_o
);
  always_comb begin
    unique case (sel_i)
      SYNC_PASS: sync_o = sync_i;
      SYNC_ZERO: sync_o = zero_i;
      default:   sync_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sync_pwm_timebase.sv
`timescale 1ns/1ps
module sync_pwm_timebase #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_PRD = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] prd_i,
  input  logic             prd_wr_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic             phase_en_i,
  input  logic             phase_dir_i,
  input  logic [1:0]       sync_sel_i,
  input  logic             sync_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             zero_o,
  output logic             prd_o,
  output logic             sync_o
);
  logic [CNT_W-1:0] prd_act;
  logic             load;
  logic             zero;

  assign load = sync_i & phase_en_i;

  utb_period_shadow #(.CNT_W(CNT_W), .RST_PRD(RST_PRD)) u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (prd_wr_i),
    .prd_i     (prd_i),
    .xfer_i    (zero),
    .prd_act_o (prd_act)
  );

  utb_updown_core #(.CNT_W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prd_act_i   (prd_act),
    .load_i      (load),
    .phase_i     (phase_i),
    .phase_dir_i (phase_dir_i),
    .cnt_o       (cnt_o),
    .dir_o       (dir_o),
    .zero_o      (zero),
    .match_o     (prd_o)
  );

  utb_sync_route u_route (
    .sel_i  (sync_sel_i),
    .sync_i (sync_i),
    .zero_i (zero),
    .sync_o (sync_o)
  );

  assign zero_o = zero;
endmodule

// File: rtl/utb_timebase_chk.sv
`timescale 1ns/1ps
module utb_timebase_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic             phase_en_i,
  input logic [CNT_W-1:0] phase_i,
  input logic             phase_dir_i,
  input logic [1:0]       sync_sel_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             dir_o,
  input logic             sync_o,
  input logic [CNT_W-1:0] prd_act
);
  // R2
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_o && cnt_o < prd_act && !(sync_i && phase_en_i)) |=> cnt_o == $past(cnt_o) + 1'b1);

  // R3
  floor_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_o && cnt_o == '0 && !(sync_i && phase_en_i)) |=> (!dir_o && cnt_o == CNT_W'(1)));

  // R4
  prd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != '0) |=> $stable(prd_act));

  // R5
  phase_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && phase_en_i) |=> (cnt_o == $past(phase_i) && dir_o == $past(phase_dir_i)));

  // R6
  sync_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_en_i && dir_o && cnt_o != '0) |=> (dir_o && cnt_o == $past(cnt_o) - 1'b1));

  // R7
  sync_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_sel_i[1] |-> !sync_o);
endmodule

bind sync_pwm_timebase utb_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_i      (sync_i),
  .phase_en_i  (phase_en_i),
  .phase_i     (phase_i),
  .phase_dir_i (phase_dir_i),
  .sync_sel_i  (sync_sel_i),
  .cnt_o       (cnt_o),
  .dir_o       (dir_o),
  .sync_o      (sync_o),
  .prd_act     (prd_act)
);

// File: tb/sync_pwm_timebase_tb.sv
`timescale 1ns/1ps
module sync_pwm_timebase_tb;
  localparam int W = 16;
  localparam int RP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] prd = '0;
  logic prd_wr = 1'b0;
  logic [W-1:0] phase = '0;
  logic phase_en = 1'b0;
  logic phase_dir = 1'b0;
  logic [1:0] sel = 2'b00;
  logic sync_in = 1'b0;
  logic [W-1:0] cnt;
  logic dir, zero, prdm, sync_out;

  always #2 clk = ~clk;

  sync_pwm_timebase #(.CNT_W(W), .RST_PRD(RP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prd_i(prd), .prd_wr_i(prd_wr),
    .phase_i(phase), .phase_en_i(phase_en), .phase_dir_i(phase_dir),
    .sync_sel_i(sel), .sync_i(sync_in), .cnt_o(cnt), .dir_o(dir),
    .zero_o(zero), .prd_o(prdm), .sync_o(sync_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  string req = "R1";
  int m_cnt, m_dir, m_act, m_sh;
  int zero_q[$];

  task automatic chk(input string r, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %0d expected %0d at %0t", r, what, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_dir = 0; m_act = RP; m_sh = RP;
  endtask

  task automatic check_all();
    int exp_sync;
    if (sel == 2'b00) exp_sync = int'(sync_in);
    else if (sel == 2'b01) exp_sync = (m_cnt == 0) ? 1 : 0;
    else exp_sync = 0;
    chk(req, "cnt_o", int'(cnt), m_cnt);
    chk(req, "dir_o", int'(dir), m_dir);
    chk("R8", "zero_o", int'(zero), (m_cnt == 0) ? 1 : 0);
    chk("R8", "prd_o", int'(prdm), (m_cnt == m_act) ? 1 : 0);
    chk("R7", "sync_o", int'(sync_out), exp_sync);
  endtask

  // advance model by one edge using current inputs, then compare
  task automatic tick();
    if (!rst_n) model_reset();
    else begin
      int nc, nd;
      bit xfer;
      xfer = (m_cnt == 0);
      nc = m_cnt; nd = m_dir;
      if (sync_in && phase_en) begin
        nc = int'(phase); nd = int'(phase_dir);
      end else if (m_dir == 0) begin
        if (m_cnt >= m_act) begin nd = 1; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
        else nc = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin nd = 0; nc = 1; end
        else nc = m_cnt - 1;
      end
      if (xfer) m_act = m_sh;
      if (prd_wr) m_sh = int'(prd);
      m_cnt = nc; m_dir = nd;
    end
    @(posedge clk);
    #1;
    if (rst_n && m_cnt == 0) zero_q.push_back($time);
    check_all();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #800000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "cnt_o reset", int'(cnt), 0);
    chk("R1", "dir_o reset", int'(dir), 0);
    rst_n = 1'b1;

    // R2 R3 free run at reset period, pass-through sync idle
    req = "R2";
    run(40);
    // R3 cycle length 2*P between zeros
    zero_q.delete();
    req = "R3";
    run(40);
    if (zero_q.size() >= 2)
      chk("R3", "zero spacing clocks", int'((zero_q[1] - zero_q[0]) / 4), 2 * RP);
    else chk("R3", "zero count", zero_q.size(), 2);

    // R4 mid-cycle write then write on zero edge
    req = "R4";
    while (!(m_cnt == 3 && m_dir == 0)) tick();
    prd = 16'd5; prd_wr = 1'b1; tick(); prd_wr = 1'b0;
    run(30);
    while (m_cnt != 0) tick();
    prd = 16'd3; prd_wr = 1'b1; tick(); prd_wr = 1'b0;
    run(30);
    prd = 16'd6; prd_wr = 1'b1; tick(); prd_wr = 1'b0;
    run(30);

    // R5 phase loads both directions, zero-pulse sync out
    req = "R5";
    sel = 2'b01; phase_en = 1'b1;
    phase = 16'd3; phase_dir = 1'b1; sync_in = 1'b1; tick(); sync_in = 1'b0;
    chk("R5", "load down cnt", int'(cnt), 3);
    chk("R5", "load down dir", int'(dir), 1);
    run(9);
    phase = 16'd2; phase_dir = 1'b0; sync_in = 1'b1; tick(); sync_in = 1'b0;
    chk("R5", "load up dir", int'(dir), 0);
    run(20);

    // R6 sync ignored with loading disabled, pass-through output
    req = "R6";
    sel = 2'b00; phase_en = 1'b0; phase = 16'd1;
    for (int k = 0; k < 6; k++) begin
      sync_in = 1'b1; tick();
      sync_in = 1'b0; tick(); tick();
    end

    // R7 disabled output across zero crossings
    req = "R7";
    sel = 2'b10;
    for (int k = 0; k < 20; k++) begin sync_in = k[0]; tick(); end
    sel = 2'b11; run(20); sync_in = 1'b0;

    // R9 phase above period, loaded going up
    req = "R9";
    sel = 2'b01; phase_en = 1'b1; phase = 16'd9; phase_dir = 1'b0;
    sync_in = 1'b1; tick(); sync_in = 1'b0;
    tick();
    chk("R9", "turn down dir", int'(dir), 1);
    chk("R9", "turn down cnt", int'(cnt), 8);
    run(30);

    // R4 minimum period of one
    req = "R4";
    prd = 16'd1; prd_wr = 1'b1; tick(); prd_wr = 1'b0;
    run(20);

    // R1 asynchronous reset mid-run
    req = "R1";
    @(posedge clk); #1;
    rst_n = 1'b0; model_reset(); #1;
    chk("R1", "cnt_o async", int'(cnt), 0);
    chk("R1", "dir_o async", int'(dir), 0);
    tick(); tick();
    rst_n = 1'b1;
    req = "R2";
    run(20);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule